// File: doc/BRIEF.md
# Gated Frequency Counter with Held Display

This block measures how often a digital input toggles. It counts the rising edges of the input over a gate window of fixed length, measured in cycles of the reference clock. The tally is kept in cascaded decimal decades. At the end of each window the finished tally is copied into a holding register. That register feeds one seven-segment decoder per decade, so the display shows a steady reading while the next window is being counted.

The input is assumed to be a clean logic level that is asynchronous to the reference clock. It passes through a two-stage synchroniser before edge detection. The window length and the number of decades are parameters. A one-cycle strobe marks each refresh of the held reading. A sticky flag, latched together with the digits, reports a tally that ran past the largest displayable value.

Top module: `freq_meter`

## Requirements
- R1: While reset is asserted and right after it is released, the held digits are all zero, the overflow flag and the strobe are low, and every digit's segment field shows the pattern for 0.
- R2: The held reading equals the number of rising edges of `sig_in` during the last completed window. Decimal digit i sits at bits [4i+3:4i] of `digits_o`, and digit 0 is the least significant.
- R3: `update_o` is high for exactly one cycle per window. The first pulse comes WINDOW cycles after reset is released, and later pulses come every WINDOW cycles. The new reading is visible in the same cycle as the pulse.
- R4: Between strobes, the held digits and the held overflow flag do not change, whatever edges are being counted.
- R5: Each decade counts 0 to 9. A decade at 9 that is incremented returns to 0 and carries one into the next decade. No decade ever holds a value above 9.
- R6: The tally restarts from zero at every window boundary. An edge that falls in the last cycle of a window is counted in that window. No edge is lost or counted in two windows.
- R7: A tally above 10^DIGITS-1 sets the overflow flag, which is latched with the wrapped low digits. A later window that does not overflow clears it.
- R8: Each digit drives a 7-bit active-high segment field at bits [7i+6:7i] of `segs_o`, with bit 0 = a through bit 6 = g. The codes for 0..9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex), and any code above 9 is blanked to 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock that times the gate window |
| rst_n | input | 1 | Asynchronous active-low reset |
| sig_in | input | 1 | Signal under measurement, asynchronous to clk |
| digits_o | output | 4*DIGITS | Held BCD reading, digit 0 lowest |
| segs_o | output | 7*DIGITS | Active-high a..g pattern for each held digit |
| ovf_o | output | 1 | Held overflow flag for the last window |
| update_o | output | 1 | One-cycle strobe when a new reading is loaded |

## Verification
Some properties are checked on every cycle. The strobe never lasts longer than one cycle. The held reading and flag change only together with the strobe. Every live and held decade stays within 0..9. The running tally and its overflow are empty in the strobe cycle, and a carry out of the top decade always sets the running overflow. Other behaviour can only be shown by the bench's scenarios: exact tallies for chosen edge counts, the spacing of the strobes, the segment patterns, the overflow wrap and its clearing, and the conservation of edges in a burst that straddles a window boundary.

// File: rtl/freq_meter.sv
module freq_meter #(
  parameter int DIGITS = 4,
  parameter int WINDOW = 1_000_000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sig_in,
  output logic [4*DIGITS-1:0]   digits_o,
  output logic [7*DIGITS-1:0]   segs_o,
  output logic                  ovf_o,
  output logic                  update_o
);
  localparam int WW = (WINDOW > 2) ? $clog2(WINDOW) : 1;
  localparam int NB = 4 * DIGITS;

  logic [2:0]      sync_q;
  logic [WW-1:0]   win_q;
  logic [NB-1:0]   cnt_q, cnt_d;
  logic            run_ovf_q, run_ovf_d;
  logic [DIGITS:0] carry;
  logic            edge_w, last_w;

  function automatic logic [6:0] seg7(input logic [3:0] v);
    case (v)
      4'd0: seg7 = 7'h3F;
      4'd1: seg7 = 7'h06;
      4'd2: seg7 = 7'h5B;
      4'd3: seg7 = 7'h4F;
      4'd4: seg7 = 7'h66;
      4'd5: seg7 = 7'h6D;
      4'd6: seg7 = 7'h7D;
      4'd7: seg7 = 7'h07;
      4'd8: seg7 = 7'h7F;
      4'd9: seg7 = 7'h6F;
      default: seg7 = 7'h00;
    endcase
  endfunction

  assign edge_w    = sync_q[1] & ~sync_q[2];
  assign last_w    = (win_q == WW'(WINDOW - 1));
  assign carry[0]  = edge_w;
  assign run_ovf_d = run_ovf_q | carry[DIGITS];

  for (genvar g = 0; g < DIGITS; g++) begin : g_dec
    logic [3:0] cur;
    assign cur = cnt_q[4*g +: 4];
    assign carry[g+1] = carry[g] & (cur == 4'd9);
    assign cnt_d[4*g +: 4] = carry[g] ? ((cur == 4'd9) ? 4'd0 : cur + 4'd1) : cur;
    assign segs_o[7*g +: 7] = seg7(digits_o[4*g +: 4]);

    // R5
    bcd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cur <= 4'd9) && (digits_o[4*g +: 4] <= 4'd9));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q    <= '0;
      win_q     <= '0;
      cnt_q     <= '0;
      run_ovf_q <= 1'b0;
      digits_o  <= '0;
      ovf_o     <= 1'b0;
      update_o  <= 1'b0;
    end else begin
      sync_q   <= {sync_q[1:0], sig_in};
      update_o <= last_w;
      if (last_w) begin
        win_q     <= '0;
        cnt_q     <= '0;
        run_ovf_q <= 1'b0;
        digits_o  <= cnt_d;
        ovf_o     <= run_ovf_d;
      end else begin
        win_q     <= win_q + 1'b1;
        cnt_q     <= cnt_d;
        run_ovf_q <= run_ovf_d;
      end
    end
  end

  // R3
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    update_o |=> !update_o);

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !update_o |-> ($stable(digits_o) && $stable(ovf_o)));

  // R6
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    update_o |-> (cnt_q == '0) && !run_ovf_q);

  // R7
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (carry[DIGITS] && !last_w) |=> run_ovf_q);
endmodule

// File: tb/freq_meter_bench.sv
module freq_meter_bench;
  localparam int DIGITS = 3;
  localparam int WIN    = 2400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sig = 1'b0;
  logic [4*DIGITS-1:0] digits;
  logic [7*DIGITS-1:0] segs;
  logic ovf, upd;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  freq_meter #(.DIGITS(DIGITS), .WINDOW(WIN)) u_freq_meter (
    .clk(clk), .rst_n(rst_n), .sig_in(sig),
    .digits_o(digits), .segs_o(segs), .ovf_o(ovf), .update_o(upd));

  function automatic logic [6:0] pat(input int d);
    logic [6:0] t [10] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66,
                           7'h6D, 7'h7D, 7'h07, 7'h7F, 7'h6F};
    return t[d];
  endfunction

  function automatic logic [4*DIGITS-1:0] to_bcd(input int v);
    logic [4*DIGITS-1:0] r;
    for (int i = 0; i < DIGITS; i++) begin
      r[4*i +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

  function automatic logic [7*DIGITS-1:0] to_segs(input int v);
    logic [7*DIGITS-1:0] r;
    for (int i = 0; i < DIGITS; i++) begin
      r[7*i +: 7] = pat(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

  function automatic int held_val();
    int v = 0;
    for (int i = DIGITS - 1; i >= 0; i--) v = v * 10 + int'(digits[4*i +: 4]);
    return v;
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_update(output int cyc);
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!upd);
  endtask

  task automatic pulses(input int n, input int half);
    for (int k = 0; k < n; k++) begin
      sig = 1'b1;
      repeat (half) @(negedge clk);
      sig = 1'b0;
      repeat (half) @(negedge clk);
    end
  endtask

  task automatic check_reading(input int edges, input string req);
    int m = edges % (10 ** DIGITS);
    chk(digits == to_bcd(m), req, digits, to_bcd(m));
    chk(segs == to_segs(m), "R8", segs, to_segs(m));
    chk(ovf == (edges >= 10 ** DIGITS), "R7", ovf, edges >= 10 ** DIGITS);
  endtask

  task automatic t_reset();
    int c;
    repeat (3) @(negedge clk);
    chk(digits == '0, "R1", digits, 0);
    chk(ovf == 1'b0 && upd == 1'b0, "R1", {ovf, upd}, 0);
    chk(segs == to_segs(0), "R1", segs, to_segs(0));
    rst_n = 1'b1;
    wait_update(c);
    chk(c == WIN, "R3 first strobe", c, WIN);
    @(negedge clk);
    chk(upd == 1'b0, "R3 width", upd, 0);
    wait_update(c);
    chk(c == WIN - 1, "R3 spacing", c + 1, WIN);
    check_reading(0, "R2");
  endtask

  task automatic t_count(input int n, input int half, input int prev, input string req);
    int c;
    repeat (5) @(negedge clk);
    pulses(n, half);
    chk(upd == 1'b0 && held_val() == prev % (10 ** DIGITS), "R4 hold", held_val(), prev % (10 ** DIGITS));
    wait_update(c);
    check_reading(n, req);
  endtask

  task automatic t_straddle(input int n);
    int a = 0, b = 0, c;
    repeat (1500) @(negedge clk);
    fork
      pulses(n, 2);
      begin
        wait_update(c);
        a = held_val();
        wait_update(c);
        b = held_val();
      end
    join
    chk(a + b == n, "R6 boundary", a + b, n);
    chk(a > 0 && b > 0, "R6 split", a, b);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    t_reset();
    t_count(7, 2, 0, "R2");
    t_count(123, 1, 7, "R2");
    t_count(999, 1, 123, "R5");
    t_count(1005, 1, 999, "R7");
    t_count(0, 1, 5, "R6 restart");
    t_count(40, 20, 0, "R2 slow");
    t_straddle(500);
    summary();
  end
endmodule